// File: doc/BRIEF.md
# Indirect PCS Register Access Bridge

This block lets a host processor reach a PCS management register space that is too wide to map directly. The space has up to 32 device groups, and each group holds registers with 16-bit addresses. The host sees only three 32-bit registers on a single-cycle write port with a combinational read path. The command register carries the operation, the device group and the register address. The data register holds a 16-bit value. The control register carries a few static PCS controls, the wait limit and two sticky error flags.

A transaction starts when the host writes the command register with its top bit set. That bit then reads back as busy until the PCS side acknowledges, and it clears by itself. For a write, the host stages the value in the data register before issuing the command. For a read, the result is placed in the data register when the acknowledge arrives. If the PCS side stays silent for longer than the programmed limit, the bridge gives up.

Top module: `pcs_reg_bridge`

## Requirements
- R1: Command register (offset 0x720) layout: bit 31 is busy/start, bit 30 selects write (1) or read (0), bits 20:16 hold the device group and bits 15:0 hold the register address. A host write with bit 31 set while idle raises `pcs_req` and presents these fields on `pcs_we`, `pcs_dev` and `pcs_addr`. The fields stay stable while the request waits.
- R2: Bit 31 of the command register reads 1 from the launch until the PCS acknowledge is seen, and it reads 0 from the following cycle. `pcs_req` drops in the cycle after the acknowledge.
- R3: For a write command, the low 16 bits of the data register (offset 0x724) are presented on `pcs_wdata`.
- R4: For a read command, `pcs_rdata` captured at the acknowledge appears in data register bits 15:0 once busy has cleared.
- R5: Data register bits 31:16 always read 0, and the upper bits of a host write to it are discarded.
- R6: Control register (offset 0x728): bit 31 drives `pcs_enable`, bit 8 drives `link_src_sel` and bit 1 drives `pcs_pwrdn`. Bits 23:16 hold the wait limit, which resets to 64. All of these read back as written.
- R7: A command write with bit 31 set while busy is ignored and sets the sticky overrun flag, control bit 3. Writing 1 to control bit 3 clears it.
- R8: If no acknowledge arrives during LIMIT+1 consecutive request cycles, the request is withdrawn, busy clears, the data register is left unchanged and the sticky timeout flag (control bit 2) is set. Writing 1 to control bit 2 clears it.
- R9: Host accesses to any other offset read 0 and change no register or output.
- R10: A data register write while busy is ignored.
- R11: A command write with bit 31 clear while idle updates the stored fields but starts no transaction.
- R12: After reset the command and data registers read 0, the control register reads 0x0040_0000, and all PCS-side and control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 12 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| pcs_req | output | 1 | Transaction request, held until acknowledge or timeout |
| pcs_we | output | 1 | 1 = write, 0 = read |
| pcs_dev | output | 5 | Device group |
| pcs_addr | output | 16 | Register address |
| pcs_wdata | output | 16 | Write value |
| pcs_ack | input | 1 | One-cycle acknowledge from the register file |
| pcs_rdata | input | 16 | Read value, valid with `pcs_ack` |
| pcs_enable | output | 1 | PCS enable control |
| link_src_sel | output | 1 | Link-status source select |
| pcs_pwrdn | output | 1 | PCS power-down control |

## Verification
The collision that matters is a new host command landing on the same clock edge on which the PCS acknowledge completes the previous transaction. The bench waits for the acknowledge to appear, and in that same cycle it drives a command write with the start bit set. It expects the read result to be stored, the new command to be dropped and counted as an overrun, and no second request to appear. The sweep over every device group, with a varying acknowledge latency, shows that completion and read capture line up with the acknowledge at every latency.

// File: rtl/pcs_reg_bridge.sv
`timescale 1ns/1ps
module pcs_reg_bridge #(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] ACC_OFS   = 12'h720,
  parameter logic [11:0] DATA_OFS  = 12'h724,
  parameter logic [11:0] CTL_OFS   = 12'h728,
  parameter int          TMO_W     = 8,
  parameter int          TMO_RESET = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              pcs_req,
  output logic              pcs_we,
  output logic [4:0]        pcs_dev,
  output logic [15:0]       pcs_addr,
  output logic [15:0]       pcs_wdata,
  input  logic              pcs_ack,
  input  logic [15:0]       pcs_rdata,
  output logic              pcs_enable,
  output logic              link_src_sel,
  output logic              pcs_pwrdn
);
  localparam logic [TMO_W-1:0] LIM_INIT = TMO_W'(TMO_RESET);

  logic             busy_q, wr_q, en_q, lsrc_q, pd_q, ovr_q, tmo_q;
  logic [4:0]       dev_q;
  logic [15:0]      adr_q, data_q;
  logic [TMO_W-1:0] limit_q, wait_q;

  wire hit_acc  = host_addr == ADDR_W'(ACC_OFS);
  wire hit_data = host_addr == ADDR_W'(DATA_OFS);
  wire hit_ctl  = host_addr == ADDR_W'(CTL_OFS);
  wire wr_acc   = host_we && hit_acc;
  wire wr_data  = host_we && hit_data;
  wire wr_ctl   = host_we && hit_ctl;
  wire done     = busy_q && pcs_ack;
  wire expire   = busy_q && !pcs_ack && (wait_q == limit_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      dev_q  <= '0;
      adr_q  <= '0;
      wait_q <= '0;
    end else if (busy_q) begin
      if (done || expire) busy_q <= 1'b0;
      else                wait_q <= wait_q + 1'b1;
    end else if (wr_acc) begin
      busy_q <= host_wdata[31];
      wr_q   <= host_wdata[30];
      dev_q  <= host_wdata[20:16];
      adr_q  <= host_wdata[15:0];
      wait_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 data_q <= '0;
    else if (done && !wr_q)     data_q <= pcs_rdata;
    else if (wr_data && !busy_q) data_q <= host_wdata[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lsrc_q  <= 1'b0;
      pd_q    <= 1'b0;
      limit_q <= LIM_INIT;
      ovr_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en_q    <= host_wdata[31];
        lsrc_q  <= host_wdata[8];
        pd_q    <= host_wdata[1];
        limit_q <= host_wdata[16 +: TMO_W];
      end
      if (wr_acc && busy_q && host_wdata[31]) ovr_q <= 1'b1;
      else if (wr_ctl && host_wdata[3])       ovr_q <= 1'b0;
      if (expire)                             tmo_q <= 1'b1;
      else if (wr_ctl && host_wdata[2])       tmo_q <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (hit_acc) begin
      host_rdata[31]    = busy_q;
      host_rdata[30]    = wr_q;
      host_rdata[20:16] = dev_q;
      host_rdata[15:0]  = adr_q;
    end else if (hit_data) begin
      host_rdata[15:0] = data_q;
    end else if (hit_ctl) begin
      host_rdata[31]           = en_q;
      host_rdata[16 +: TMO_W]  = limit_q;
      host_rdata[8]            = lsrc_q;
      host_rdata[3]            = ovr_q;
      host_rdata[2]            = tmo_q;
      host_rdata[1]            = pd_q;
    end
  end

  assign pcs_req      = busy_q;
  assign pcs_we       = wr_q;
  assign pcs_dev      = dev_q;
  assign pcs_addr     = adr_q;
  assign pcs_wdata    = data_q;
  assign pcs_enable   = en_q;
  assign link_src_sel = lsrc_q;
  assign pcs_pwrdn    = pd_q;
endmodule

// File: rtl/pcs_reg_bridge_chk.sv
`timescale 1ns/1ps
module pcs_reg_bridge_chk #(
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] ACC_OFS  = 12'h720,
  parameter logic [11:0] DATA_OFS = 12'h724,
  parameter logic [11:0] CTL_OFS  = 12'h728,
  parameter int          TMO_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [31:0]       host_wdata,
  input logic [31:0]       host_rdata,
  input logic              pcs_req,
  input logic              pcs_we,
  input logic [4:0]        pcs_dev,
  input logic [15:0]       pcs_addr,
  input logic [15:0]       pcs_wdata,
  input logic              pcs_ack,
  input logic [TMO_W-1:0]  limit_q,
  input logic              ovr_q,
  input logic              tmo_q
);
  logic [TMO_W:0] stall_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                 stall_cnt <= '0;
    else if (pcs_req && !pcs_ack) stall_cnt <= stall_cnt + 1'b1;
    else                        stall_cnt <= '0;
  end

  wire known = (host_addr == ADDR_W'(ACC_OFS)) || (host_addr == ADDR_W'(DATA_OFS)) ||
               (host_addr == ADDR_W'(CTL_OFS));

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_req && !pcs_ack |=> !pcs_req ||
      ($stable(pcs_dev) && $stable(pcs_addr) && $stable(pcs_we) && $stable(pcs_wdata)));

  // R2
  ack_ends_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_req && pcs_ack |=> !pcs_req);

  // R5
  data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == ADDR_W'(DATA_OFS) |-> host_rdata[31:16] == 16'h0);

  // R9
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> host_rdata == 32'h0);

  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(host_we && host_addr == ADDR_W'(ACC_OFS) && host_wdata[31] && pcs_req));

  // R8
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_req |-> stall_cnt <= {1'b0, limit_q});

  // R8
  timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(pcs_req && !pcs_ack) && !pcs_req);
endmodule

bind pcs_reg_bridge pcs_reg_bridge_chk #(
  .ADDR_W(ADDR_W), .ACC_OFS(ACC_OFS), .DATA_OFS(DATA_OFS), .CTL_OFS(CTL_OFS), .TMO_W(TMO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .pcs_req(pcs_req),
  .pcs_we(pcs_we), .pcs_dev(pcs_dev), .pcs_addr(pcs_addr), .pcs_wdata(pcs_wdata),
  .pcs_ack(pcs_ack), .limit_q(limit_q), .ovr_q(ovr_q), .tmo_q(tmo_q)
);

// File: tb/tb_pcs_reg_bridge.sv
`timescale 1ns/1ps
module tb_pcs_reg_bridge;
  localparam logic [11:0] ACC = 12'h720, DAT = 12'h724, CTL = 12'h728;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic pcs_req, pcs_we, pcs_enable, link_src_sel, pcs_pwrdn;
  logic [4:0] pcs_dev;
  logic [15:0] pcs_addr, pcs_wdata;
  logic pcs_ack = 1'b0;
  logic [15:0] pcs_rdata = '0;

  always #4 clk = ~clk;

  pcs_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pcs_req(pcs_req),
    .pcs_we(pcs_we), .pcs_dev(pcs_dev), .pcs_addr(pcs_addr), .pcs_wdata(pcs_wdata),
    .pcs_ack(pcs_ack), .pcs_rdata(pcs_rdata), .pcs_enable(pcs_enable),
    .link_src_sel(link_src_sel), .pcs_pwrdn(pcs_pwrdn)
  );

  // register file model
  logic [15:0] mem [0:511];
  logic [1:0]  lat = '0;
  logic        mute = 1'b0;
  logic [1:0]  mcnt = '0;
  int          txn = 0;
  logic        last_we;
  logic [4:0]  last_dev;
  logic [15:0] last_addr, last_wdata;

  always @(posedge clk) begin
    if (pcs_ack) begin
      pcs_ack <= 1'b0;
      mcnt    <= '0;
    end else if (pcs_req && !mute) begin
      if (mcnt == lat) begin
        pcs_ack    <= 1'b1;
        pcs_rdata  <= mem[{pcs_dev, pcs_addr[3:0]}];
        if (pcs_we) mem[{pcs_dev, pcs_addr[3:0]}] <= pcs_wdata;
        last_we    <= pcs_we;
        last_dev   <= pcs_dev;
        last_addr  <= pcs_addr;
        last_wdata <= pcs_wdata;
        txn        <= txn + 1;
      end else mcnt <= mcnt + 1'b1;
    end else mcnt <= '0;
  end

  int checks = 0, failures = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [11:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle(output int seen);
    logic [31:0] v;
    seen = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      hr(ACC, v);
      if (!v[31]) break;
      seen++;
    end
  endtask

  function automatic logic [15:0] pat(input int d, input int a);
    return 16'(d * 16'h0101) ^ 16'(a * 16'h1357) ^ 16'h5A5A;
  endfunction

  localparam logic [31:0] LIM64 = 32'h0040_0000;

  initial begin
    logic [31:0] v;
    int seen, t0;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    hr(ACC, v); chk(v == 0, "R12 acc", v, 0);
    hr(DAT, v); chk(v == 0, "R12 data", v, 0);
    hr(CTL, v); chk(v == LIM64, "R12 ctl", v, LIM64);
    chk({pcs_req, pcs_enable, link_src_sel, pcs_pwrdn} == 0, "R12 outs",
        {pcs_req, pcs_enable, link_src_sel, pcs_pwrdn}, 0);

    // R6 all control-bit combinations
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w;
      w = LIM64 | (k[0] ? 32'h8000_0000 : 0) | (k[1] ? 32'h100 : 0) | (k[2] ? 32'h2 : 0);
      hw(CTL, w);
      hr(CTL, v); chk(v == w, "R6 ctl readback", v, w);
      chk({pcs_enable, link_src_sel, pcs_pwrdn} == {k[0], k[1], k[2]}, "R6 outs",
          {pcs_enable, link_src_sel, pcs_pwrdn}, {k[0], k[1], k[2]});
    end
    hw(CTL, LIM64);

    // R5 upper data bits
    hw(DAT, 32'hFFFF_1234);
    hr(DAT, v); chk(v == 32'h0000_1234, "R5 data upper", v, 32'h1234);

    // R11 command without start bit
    t0 = txn;
    hw(ACC, 32'h4003_0042);
    repeat (4) begin
      @(negedge clk);
      chk(!pcs_req, "R11 no req", pcs_req, 0);
    end
    hr(ACC, v); chk(v == 32'h4003_0042, "R11 fields", v, 32'h4003_0042);
    chk(txn == t0, "R11 no txn", txn, t0);

    // R1 R2 R3 write sweep
    for (int d = 0; d < 32; d++)
      for (int a = 0; a < 16; a++) begin
        logic [15:0] ad;
        ad = 16'(a * 16'h1111);
        lat = 2'((d + a) % 4);
        hw(DAT, {16'hA5A5, pat(d, a)});
        hw(ACC, 32'hC000_0000 | (32'(d) << 16) | 32'(ad));
        @(negedge clk);
        chk(pcs_req && pcs_we && pcs_dev == 5'(d) && pcs_addr == ad, "R1 req fields",
            {pcs_req, pcs_we, 3'b0, pcs_dev, pcs_addr}, {2'b11, 3'b0, 5'(d), ad});
        hr(ACC, v); chk(v[31], "R1 busy reads 1", v, 32'h8000_0000);
        wait_idle(seen);
        chk(seen == int'(lat), "R2 busy length", seen, lat);
        chk(last_we && last_dev == 5'(d) && last_addr == ad && last_wdata == pat(d, a),
            "R3 write delivered", {last_we, last_dev, last_addr}, {1'b1, 5'(d), ad});
      end

    // R4 read sweep
    for (int d = 0; d < 32; d++)
      for (int a = 0; a < 16; a++) begin
        lat = 2'((d * 3 + a) % 4);
        hw(ACC, 32'h8000_0000 | (32'(d) << 16) | 32'(a * 16'h1111));
        wait_idle(seen);
        hr(DAT, v);
        chk(v == {16'h0, pat(d, a)} && !last_we, "R4 read result", v, {16'h0, pat(d, a)});
      end

    // R10 data write during read ignored
    lat = 2'd3;
    hw(ACC, 32'h8005_0555);
    hw(DAT, 32'h0000_BEEF);
    wait_idle(seen);
    hr(DAT, v); chk(v == {16'h0, pat(5, 5)}, "R10 busy data write", v, {16'h0, pat(5, 5)});

    // R7 command on the completion edge
    lat = 2'd2;
    t0 = txn;
    hw(ACC, 32'h8009_0333);
    @(negedge clk);
    while (!pcs_ack) @(negedge clk);
    host_addr = ACC; host_wdata = 32'h8007_0999; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    hr(ACC, v); chk(v == 32'h0009_0333, "R7 cmd dropped", v, 32'h0009_0333);
    hr(DAT, v); chk(v == {16'h0, pat(9, 3)}, "R7 read kept", v, {16'h0, pat(9, 3)});
    hr(CTL, v); chk(v[3], "R7 overrun set", v, LIM64 | 8);
    repeat (3) @(negedge clk);
    chk(!pcs_req && txn == t0 + 1, "R7 no second req", txn, t0 + 1);
    hw(CTL, LIM64 | 32'h8);
    hr(CTL, v); chk(v == LIM64, "R7 overrun cleared", v, LIM64);

    // R8 timeout
    hw(CTL, 32'h0005_0000);
    mute = 1'b1;
    hw(ACC, 32'h8002_0001);
    wait_idle(seen);
    chk(seen == 5, "R8 abandon time", seen, 5);
    hr(DAT, v); chk(v == {16'h0, pat(9, 3)}, "R8 data kept", v, {16'h0, pat(9, 3)});
    hr(CTL, v); chk(v == 32'h0005_0004, "R8 timeout set", v, 32'h0005_0004);
    chk(!pcs_req, "R8 req withdrawn", pcs_req, 0);
    mute = 1'b0;
    hw(CTL, 32'h0005_0004);
    hr(CTL, v); chk(v == 32'h0005_0000, "R8 timeout cleared", v, 32'h0005_0000);

    // R9 undefined offsets
    hw(12'h72C, 32'hFFFF_FFFF);
    hw(12'h000, 32'hFFFF_FFFF);
    hr(12'h72C, v); chk(v == 0, "R9 undef read", v, 0);
    hr(12'h000, v); chk(v == 0, "R9 undef read 0", v, 0);
    hr(CTL, v); chk(v == 32'h0005_0000, "R9 ctl untouched", v, 32'h0005_0000);
    hr(ACC, v); chk(v == 32'h0002_0001, "R9 acc untouched", v, 32'h0002_0001);
    hr(DAT, v); chk(v == {16'h0, pat(9, 3)}, "R9 data untouched", v, {16'h0, pat(9, 3)});
    chk(!pcs_req && !pcs_enable && !pcs_pwrdn && !link_src_sel, "R9 outs", 0, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule